// File: doc/BRIEF.md
# Address Decoder with Recently-Used Range Cache

This block turns a request address into a destination port number. Every destination owns one programmable address window, given as an inclusive base and limit plus an enable bit. A further window belongs to the default device. Three recently matched windows are kept in a small cache in front of the window table. A lookup that hits the cache is answered one cycle after it is accepted. A lookup that misses spends one more cycle searching the table. On a match it returns the destination and pushes that window into the cache.

Addresses that no destination claims are sent to the default port, whose number is one above the highest destination. When the range-check option is set, such an address must also fall inside the default device's window, or the response carries an error flag. The cache is emptied by an explicit clear input and by any write to the window table. A stale window can therefore never answer a lookup after the table has changed.

Top module: `adec_mru_decoder`

## Requirements
- R1: After reset `resp_valid` is 0, `req_ready` is 1, and the cache is empty, so the first lookup takes the miss path.
- R2: A lookup that misses the cache is answered with `resp_valid` two cycles after the accepting edge. `req_ready` is 0 for exactly the one cycle in between.
- R3: A table search returns the lowest-numbered enabled destination whose window holds the address, with inclusive limits at both ends.
- R4: A lookup that hits the cache is answered one cycle after the accepting edge with the cached port number. A hit does not reorder the cache.
- R5: A table match writes its window and port into cache slot 0. Slot 0 moves to slot 1 and slot 1 moves to slot 2. The window in slot 2 is lost, so the fourth distinct window inserted evicts the first.
- R6: Cache slots are examined from slot 0 upward, and the first valid slot whose window holds the address answers.
- R7: With the range-check option clear, an unmatched address returns port N_DST (the default port) with `resp_err` 0.
- R8: With the range-check option set, an unmatched address returns port N_DST. `resp_err` is 0 when the default window is enabled and holds the address, and 1 otherwise.
- R9: A `cache_clr` pulse empties the cache. A lookup accepted in the same cycle still sees the cache contents from before the clear.
- R10: Any `cfg_we` write empties the cache. `cfg_idx` 0..N_DST-1 selects a destination window, `cfg_idx` N_DST selects the default window, and larger values change no window.
- R11: A clear that falls in the cycle where a miss completes wins over the insertion, so no window is cached.
- R12: Default-port results are never cached, so each unmatched lookup takes the miss path.
- R13: A destination whose enable bit is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window write strobe (also empties the cache) |
| cfg_idx | input | 3 | Window selector: destinations 0..3, 4 = default window |
| cfg_base | input | 32 | Lowest address of the window |
| cfg_limit | input | 32 | Highest address of the window (inclusive) |
| cfg_en | input | 1 | Window enable |
| use_dflt_range | input | 1 | Range-check the default port against its own window |
| cache_clr | input | 1 | Empty the cache |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Lookup address |
| req_ready | output | 1 | Ready for a new lookup (low during a table search) |
| resp_valid | output | 1 | Lookup result valid for one cycle |
| resp_port | output | 3 | Resulting port number (4 = default port) |
| resp_err | output | 1 | Address outside every window while range-checking is on |

## Verification
The contested cycle is the edge where a miss completes its table search and wants to insert into the cache while a clear arrives, either through `cache_clr` or through a `cfg_we` write. The bench launches a miss and raises the clear in the search cycle. It then expects the response itself to be correct and the next lookup to the same window to take the two-cycle miss path again. A second scenario raises `cache_clr` together with a request that would hit. It expects a one-cycle hit answer from the old contents, followed by a miss on the repeat lookup.

// File: rtl/adec_pkg.sv
package adec_pkg;

    localparam int unsigned ADEC_AW      = 32;
    localparam int unsigned ADEC_NDST    = 4;
    localparam int unsigned ADEC_PW      = $clog2(ADEC_NDST + 1);
    localparam int unsigned ADEC_CACHE_N = 3;

    typedef logic [ADEC_AW-1:0] addr_t;
    typedef logic [ADEC_PW-1:0] pid_t;

    localparam pid_t ADEC_DFLT_PID = pid_t'(ADEC_NDST);

    // one programmable window
    typedef struct packed {
        logic  en;
        addr_t base;
        addr_t limit;
    } win_t;

    // one cache slot
    typedef struct packed {
        logic  vld;
        pid_t  pid;
        addr_t base;
        addr_t limit;
    } cslot_t;

    typedef enum logic {ST_IDLE, ST_SEARCH} dec_st_e;

    function automatic logic covers(addr_t lo, addr_t hi, addr_t a);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/adec_win_table.sv
module adec_win_table
    import adec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  pid_t  idx,
    input  addr_t base,
    input  addr_t limit,
    input  logic  en,
    input  addr_t addr,
    output logic  hit,
    output pid_t  pid,
    output addr_t m_base,
    output addr_t m_limit,
    output logic  dflt_in
);
    localparam int unsigned NWIN = ADEC_NDST + 1;

    win_t tbl [NWIN];

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            always_ff @(posedge clk) begin
                if (rst)
                    tbl[g] <= '0;
                else if (we && (idx == pid_t'(g)))
                    tbl[g] <= '{en: en, base: base, limit: limit};
            end
        end
    endgenerate

    // descending scan: lowest matching destination overrides the others
    always_comb begin
        hit     = 1'b0;
        pid     = '0;
        m_base  = '0;
        m_limit = '0;
        for (int i = ADEC_NDST - 1; i >= 0; i--) begin
            if (tbl[i].en && covers(tbl[i].base, tbl[i].limit, addr)) begin
                hit     = 1'b1;
                pid     = pid_t'(i);
                m_base  = tbl[i].base;
                m_limit = tbl[i].limit;
            end
        end
    end

    assign dflt_in = tbl[ADEC_NDST].en &&
                     covers(tbl[ADEC_NDST].base, tbl[ADEC_NDST].limit, addr);

endmodule

// File: rtl/adec_mru_cache.sv
module adec_mru_cache
    import adec_pkg::*;
#(
    parameter int unsigned DEPTH = ADEC_CACHE_N
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  addr_t            lk_addr,
    output logic             lk_hit,
    output pid_t             lk_pid,
    input  logic             ins_en,
    input  pid_t             ins_pid,
    input  addr_t            ins_base,
    input  addr_t            ins_limit,
    output logic [DEPTH-1:0] vld
);
    cslot_t slot [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst || clr)
                        slot[g] <= '0;
                    else if (ins_en)
                        slot[g] <= '{vld: 1'b1, pid: ins_pid,
                                     base: ins_base, limit: ins_limit};
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst || clr)
                        slot[g] <= '0;
                    else if (ins_en)
                        slot[g] <= slot[g-1];
                end
            end
            assign vld[g] = slot[g].vld;
        end
    endgenerate

    // slot 0 has precedence: scan downward so lower slots override
    always_comb begin
        lk_hit = 1'b0;
        lk_pid = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (slot[i].vld && covers(slot[i].base, slot[i].limit, lk_addr)) begin
                lk_hit = 1'b1;
                lk_pid = slot[i].pid;
            end
        end
    end

endmodule

// File: rtl/adec_mru_decoder.sv
module adec_mru_decoder
    import adec_pkg::*;
#(
    parameter int unsigned CACHE_N = ADEC_CACHE_N
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADEC_PW-1:0]   cfg_idx,
    input  logic [ADEC_AW-1:0]   cfg_base,
    input  logic [ADEC_AW-1:0]   cfg_limit,
    input  logic                 cfg_en,
    input  logic                 use_dflt_range,
    input  logic                 cache_clr,
    input  logic                 req_valid,
    input  logic [ADEC_AW-1:0]   req_addr,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic [ADEC_PW-1:0]   resp_port,
    output logic                 resp_err
);
    dec_st_e st;
    addr_t   pend_addr;

    logic    t_hit, t_dflt_in;
    pid_t    t_pid;
    addr_t   t_base, t_limit;
    logic    c_hit;
    pid_t    c_pid;
    logic    ins_en, flush;
    logic [CACHE_N-1:0] cache_vld;
    logic    acc;

    assign req_ready = (st == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign flush     = cache_clr || cfg_we;
    assign ins_en    = (st == ST_SEARCH) && t_hit;

    adec_win_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .base    (cfg_base),
        .limit   (cfg_limit),
        .en      (cfg_en),
        .addr    (pend_addr),
        .hit     (t_hit),
        .pid     (t_pid),
        .m_base  (t_base),
        .m_limit (t_limit),
        .dflt_in (t_dflt_in)
    );

    adec_mru_cache #(.DEPTH(CACHE_N)) u_cache (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .lk_addr   (req_addr),
        .lk_hit    (c_hit),
        .lk_pid    (c_pid),
        .ins_en    (ins_en),
        .ins_pid   (t_pid),
        .ins_base  (t_base),
        .ins_limit (t_limit),
        .vld       (cache_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pend_addr  <= '0;
            resp_valid <= 1'b0;
            resp_port  <= '0;
            resp_err   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    resp_valid <= 1'b0;
                    if (acc) begin
                        if (c_hit) begin
                            resp_valid <= 1'b1;
                            resp_port  <= c_pid;
                            resp_err   <= 1'b0;
                        end else begin
                            pend_addr <= req_addr;
                            st        <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    resp_valid <= 1'b1;
                    st         <= ST_IDLE;
                    if (t_hit) begin
                        resp_port <= t_pid;
                        resp_err  <= 1'b0;
                    end else begin
                        resp_port <= ADEC_DFLT_PID;
                        resp_err  <= use_dflt_range && !t_dflt_in;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adec_checker.sv
module adec_checker
    import adec_pkg::*;
#(
    parameter int unsigned CACHE_N = ADEC_CACHE_N
)(
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic               cache_clr,
    input logic               use_dflt_range,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic [ADEC_PW-1:0] resp_port,
    input logic               resp_err,
    input logic               ins_en,
    input logic [CACHE_N-1:0] cache_vld
);
    // R2 / R4: an accepted lookup either answers next cycle or blocks
    p_answer_or_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (resp_valid != !req_ready));

    // R2: the search lasts exactly one cycle
    p_search_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (resp_valid && req_ready));

    // R4: a response always has an accepted request or a search behind it
    p_resp_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

    // R3: port numbers never exceed the default port
    p_port_legal_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_port <= ADEC_DFLT_PID));

    // R8: an error is only reported on the default port
    p_err_on_default_r8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (resp_port == ADEC_DFLT_PID));

    // R7: no error when range-checking was off
    p_err_needs_option_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> $past(use_dflt_range));

    // R9 and R10: clear or table write empties every slot
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        (cache_clr || cfg_we) |=> (cache_vld == '0));

    // R5: an insertion without a clear fills slot 0
    p_insert_head_r5: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !cache_clr && !cfg_we) |=> cache_vld[0]);

endmodule

bind adec_mru_decoder adec_checker #(.CACHE_N(CACHE_N)) u_adec_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_we         (cfg_we),
    .cache_clr      (cache_clr),
    .use_dflt_range (use_dflt_range),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_port      (resp_port),
    .resp_err       (resp_err),
    .ins_en         (ins_en),
    .cache_vld      (cache_vld)
);

// File: tb/test_adec_mru_decoder.sv
`timescale 1ns/1ps
module test_adec_mru_decoder;
    import adec_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0, cfg_limit = '0;
    logic        cfg_en = 1'b0;
    logic        use_dflt_range = 1'b0;
    logic        cache_clr = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_err;
    logic [2:0]  resp_port;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    adec_mru_decoder i_adec_mru_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_en(cfg_en),
        .use_dflt_range(use_dflt_range), .cache_clr(cache_clr),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_port(resp_port), .resp_err(resp_err)
    );

    localparam logic [2:0] DFLT = 3'd4;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic program_win(input logic [2:0] idx, input logic [31:0] b,
                               input logic [31:0] l, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = b; cfg_limit = l; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); cache_clr = 1'b1;
        @(negedge clk); cache_clr = 1'b0;
    endtask

    // issue one lookup and check latency, port and error flag
    task automatic lookup(input logic [31:0] a, input logic [2:0] exp_pid,
                          input logic exp_err, input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, req, $sformatf("latency @%0h", a), lat, exp_lat);
        chk(resp_port == exp_pid, req, $sformatf("port @%0h", a), resp_port, exp_pid);
        chk(resp_err == exp_err, req, $sformatf("err @%0h", a), resp_err, exp_err);
    endtask

    task automatic base_map();
        program_win(3'd0, 32'h1000, 32'h1FFF, 1'b1);
        program_win(3'd1, 32'h2000, 32'h2FFF, 1'b1);
        program_win(3'd2, 32'h3000, 32'h3FFF, 1'b1);
        program_win(3'd3, 32'h4000, 32'h4FFF, 1'b1);
        program_win(3'd4, 32'h8000, 32'h8FFF, 1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        base_map();
        lookup(32'h1000, 3'd0, 1'b0, 2, "R1");
    endtask

    task automatic t_miss_hit();
        pulse_clear();
        // R2: ready drops for one cycle on a miss
        @(negedge clk); req_valid = 1'b1; req_addr = 32'h2FFF;
        @(negedge clk); req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready during search", req_ready, 0);
        chk(resp_valid == 1'b0, "R2", "no early resp", resp_valid, 0);
        @(negedge clk);
        chk(resp_valid == 1'b1, "R2", "resp after search", resp_valid, 1);
        chk(resp_port == 3'd1, "R2", "miss port", resp_port, 1);
        chk(req_ready == 1'b1, "R2", "ready after search", req_ready, 1);
        lookup(32'h2000, 3'd1, 1'b0, 1, "R4");
        lookup(32'h1FFF, 3'd0, 1'b0, 2, "R3");
        lookup(32'h1FFF, 3'd0, 1'b0, 1, "R4");
    endtask

    task automatic t_evict();
        pulse_clear();
        lookup(32'h1010, 3'd0, 1'b0, 2, "R5");
        lookup(32'h2010, 3'd1, 1'b0, 2, "R5");
        lookup(32'h3010, 3'd2, 1'b0, 2, "R5");
        lookup(32'h4010, 3'd3, 1'b0, 2, "R5");
        lookup(32'h2020, 3'd1, 1'b0, 1, "R5");
        lookup(32'h3020, 3'd2, 1'b0, 1, "R5");
        lookup(32'h4020, 3'd3, 1'b0, 1, "R5");
        lookup(32'h1020, 3'd0, 1'b0, 2, "R5");
        // window 1 now pushed out; hits did not reorder
        lookup(32'h2030, 3'd1, 1'b0, 2, "R5");
    endtask

    task automatic t_default();
        use_dflt_range = 1'b0;
        lookup(32'h9000, DFLT, 1'b0, 2, "R7");
        lookup(32'h9000, DFLT, 1'b0, 2, "R12");
        use_dflt_range = 1'b1;
        lookup(32'h8100, DFLT, 1'b0, 2, "R8");
        lookup(32'h8FFF, DFLT, 1'b0, 2, "R8");
        lookup(32'h9000, DFLT, 1'b1, 2, "R8");
        lookup(32'h0000, DFLT, 1'b1, 2, "R8");
        program_win(3'd4, 32'h8000, 32'h8FFF, 1'b0);
        lookup(32'h8100, DFLT, 1'b1, 2, "R8");
        program_win(3'd4, 32'h8000, 32'h8FFF, 1'b1);
        use_dflt_range = 1'b0;
    endtask

    task automatic t_disable_overlap();
        program_win(3'd2, 32'h3000, 32'h3FFF, 1'b0);
        lookup(32'h3010, DFLT, 1'b0, 2, "R13");
        program_win(3'd1, 32'h1800, 32'h27FF, 1'b1);
        lookup(32'h1900, 3'd0, 1'b0, 2, "R3");
        lookup(32'h2400, 3'd1, 1'b0, 2, "R3");
        // R6: wide window 1 cached in slot 0 answers ahead of window 0
        program_win(3'd1, 32'h0000, 32'hFFFF, 1'b1);
        lookup(32'h1100, 3'd0, 1'b0, 2, "R6");
        lookup(32'h5000, 3'd1, 1'b0, 2, "R6");
        lookup(32'h1100, 3'd1, 1'b0, 1, "R6");
        base_map();
    endtask

    task automatic t_flush();
        lookup(32'h4100, 3'd3, 1'b0, 2, "R10");
        lookup(32'h4100, 3'd3, 1'b0, 1, "R10");
        program_win(3'd3, 32'h4000, 32'h4FFF, 1'b1);
        lookup(32'h4100, 3'd3, 1'b0, 2, "R10");
        program_win(3'd6, 32'h0000, 32'hFFFF, 1'b1);  // no such window
        lookup(32'h4100, 3'd3, 1'b0, 2, "R10");
        lookup(32'h9100, DFLT, 1'b0, 2, "R10");
        pulse_clear();
        lookup(32'h4100, 3'd3, 1'b0, 2, "R9");
    endtask

    task automatic t_collide();
        // R11: clear lands on the insertion edge
        @(negedge clk); req_valid = 1'b1; req_addr = 32'h3100;
        @(negedge clk); req_valid = 1'b0; cache_clr = 1'b1;
        @(negedge clk); cache_clr = 1'b0;
        chk(resp_valid == 1'b1, "R11", "resp with clear", resp_valid, 1);
        chk(resp_port == 3'd2, "R11", "port with clear", resp_port, 2);
        lookup(32'h3100, 3'd2, 1'b0, 2, "R11");
        // R9: clear together with a hitting request
        @(negedge clk); req_valid = 1'b1; req_addr = 32'h3200; cache_clr = 1'b1;
        @(negedge clk); req_valid = 1'b0; cache_clr = 1'b0;
        chk(resp_valid == 1'b1, "R9", "hit with clear valid", resp_valid, 1);
        chk(resp_port == 3'd2, "R9", "hit with clear port", resp_port, 2);
        lookup(32'h3200, 3'd2, 1'b0, 2, "R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_miss_hit();
        t_evict();
        t_default();
        t_disable_overlap();
        t_flush();
        t_collide();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule